// File: doc/BRIEF.md
# System Clock Source Select and Divider

This block produces the CPU clock of a small microcontroller from one of two oscillators: a fast main oscillator and a slow 32.768 kHz watch-crystal oscillator. Software programs one 8-bit control register over a simple register bus. The register picks the source and the divide ratio, and it can shut the main oscillator down once the slow oscillator is running the core. Changing the source uses a cross-coupled handshake that is synchronized in each oscillator domain. Only one oscillator is gated onto the output at any time, and both are gated off while the change is in progress.

The selected clock feeds a free-running 4-bit counter. The CPU clock is either the selected clock passed straight through or one counter bit, which gives a ratio of 2, 4, 8 or 16 with a 50% duty cycle. A new ratio takes effect only when the counter wraps, so no period is ever cut short. Software must pick a ratio that keeps timer event rates within one sixth of the CPU clock, and timer clocks within one half of it. A status output shows which oscillator currently drives the core, so software can poll until a switch has completed.

Top module: `sysclk_ctrl`

## Requirements
- R1: The control register answers at address 0x80 only. A write there stores bits 3:0 (bit 3 = slow-source select, bits 2:0 = rate code). A read of 0x80 returns the stored value. A write to any other address changes nothing, and a read of any other address returns 0.
- R2: Bits 7:5 of the register always read 0. After reset the register reads 0x00, `main_osc_en` is 1 and `sub_active` is 0.
- R3: Rate code 0, 1, 2 or 3 (bit 2 clear) gives a CPU clock equal to the selected oscillator. Code 4 divides it by 2, 5 by 4, 6 by 8 and 7 by 16.
- R4: For every dividing code the CPU clock is high for exactly half of each of its periods.
- R5: Setting bit 3 moves the CPU clock to the slow oscillator, and clearing it moves the clock back to the main oscillator. `sub_active` reports the source that currently drives the clock. The two oscillators are never gated onto the output at the same time.
- R6: A write with bit 4 set stores the stop flag only if bit 3 of the same write is 1 and `sub_active` is already 1. Otherwise bit 4 reads back 0. `main_osc_en` is the inverse of the stored stop flag, and it is low only while `sub_active` is 1.
- R7: A write to 0x80 with bit 3 clear also clears the stop flag, so `main_osc_en` is 1 in the bus cycle after that write.
- R8: The active rate code changes only at the selected-clock edge where the counter wraps to zero, so a change of ratio never produces a shortened high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk | input | 1 | Fast main oscillator clock |
| sub_clk | input | 1 | Slow 32.768 kHz oscillator clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data, combinational from `addr` |
| main_osc_en | output | 1 | Enable for the main oscillator (0 = stopped) |
| sub_active | output | 1 | 1 when the slow oscillator drives the CPU clock |
| cpu_clk | output | 1 | Generated CPU clock |

## Verification
Register writes appear on `rd_data` and on `main_osc_en` in the bus cycle after the write edge. The bench therefore samples them at the falling bus edge that closes the write. A source change finishes only after two falling edges in each oscillator domain plus two bus cycles, so the bench allows a fixed margin of 150 bus cycles before it samples `sub_active`. A new rate code needs two selected-clock cycles to synchronize and up to sixteen more to reach a counter wrap. The bench waits 48 selected-clock cycles before it counts rising edges and high samples over a window that is an exact multiple of sixteen periods. Window edges sit 3 ns after a reference rising edge, away from every CPU-clock transition.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int SEL_W  = 3;
  localparam int STEP_W = SEL_W - 1;
  localparam int CNT_W  = 1 << STEP_W;

  typedef struct packed {
    logic             halt_main;
    logic             use_sub;
    logic [SEL_W-1:0] rate;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic rate_bypass(input logic [SEL_W-1:0] rate);
    return !rate[SEL_W-1];
  endfunction

  function automatic int rate_ratio(input logic [SEL_W-1:0] rate);
    return rate_bypass(rate) ? 1 : (2 << rate[STEP_W-1:0]);
  endfunction
endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter bit         NEG     = 1'b0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    if (NEG) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sub_active,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic  hit;
  logic  wr_hit;
  ctrl_t wr_val;
  logic  unused_rsv;

  assign hit    = (addr == CTRL_ADDR);
  assign wr_hit = wr_en && hit;

  // the stop request survives only when the slow clock already runs the core
  always_comb begin
    wr_val.use_sub   = wdata[SEL_W];
    wr_val.rate      = wdata[SEL_W-1:0];
    wr_val.halt_main = wdata[SEL_W+1] && wdata[SEL_W] && sub_active;
  end

  assign unused_rsv = ^wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= wr_val;
  end

  assign rd_data = hit ? {{PAD_W{1'b0}}, ctrl_q} : '0;
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch #(
  parameter int SYNC_N = 2
) (
  input  logic rst_n,
  input  logic main_clk,
  input  logic sub_clk,
  input  logic want_sub,
  output logic main_on,
  output logic sub_on,
  output logic sel_clk
);
  logic main_req;
  logic sub_req;

  // each side asks only once the other side has let go
  assign main_req = !want_sub && !sub_on;
  assign sub_req  = want_sub && !main_on;

  sysclk_sync #(.W(1), .STAGES(SYNC_N), .NEG(1'b1), .RST_VAL(1'b1)) u_main_gate (
    .clk(main_clk), .rst_n(rst_n), .d(main_req), .q(main_on)
  );

  sysclk_sync #(.W(1), .STAGES(SYNC_N), .NEG(1'b1), .RST_VAL(1'b0)) u_sub_gate (
    .clk(sub_clk), .rst_n(rst_n), .d(sub_req), .q(sub_on)
  );

  assign sel_clk = (main_clk && main_on) || (sub_clk && sub_on);
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
  import sysclk_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             rst_n,
  input  logic             sel_clk,
  input  logic [SEL_W-1:0] rate_in,
  output logic [CNT_W-1:0] div_cnt,
  output logic [SEL_W-1:0] act_rate,
  output logic             wrap,
  output logic             cpu_clk
);
  logic [SEL_W-1:0] rate_s;
  logic             div_bit;

  sysclk_sync #(.W(SEL_W), .STAGES(SYNC_N), .NEG(1'b1), .RST_VAL('0)) u_rate_sync (
    .clk(sel_clk), .rst_n(rst_n), .d(rate_in), .q(rate_s)
  );

  assign wrap = &div_cnt;

  // all state moves on the falling edge, while the selected clock is low
  always_ff @(negedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      act_rate <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      if (wrap) act_rate <= rate_s;
    end
  end

  assign div_bit = div_cnt[act_rate[STEP_W-1:0]];
  assign cpu_clk = rate_bypass(act_rate) ? sel_clk : div_bit;
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h80,
  parameter int              SYNC_N    = 2
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              main_clk,
  input  logic              sub_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              main_osc_en,
  output logic              sub_active,
  output logic              cpu_clk
);
  ctrl_t            ctrl_q;
  logic             main_on;
  logic             sub_on;
  logic             sel_clk;
  logic [CNT_W-1:0] div_cnt;
  logic [SEL_W-1:0] act_rate;
  logic             div_wrap;

  sysclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sub_active(sub_active), .ctrl_q(ctrl_q), .rd_data(rd_data)
  );

  sysclk_sync #(.W(1), .STAGES(SYNC_N), .NEG(1'b0), .RST_VAL(1'b0)) u_status_sync (
    .clk(bus_clk), .rst_n(rst_n), .d(sub_on), .q(sub_active)
  );

  sysclk_switch #(.SYNC_N(SYNC_N)) u_switch (
    .rst_n(rst_n), .main_clk(main_clk), .sub_clk(sub_clk), .want_sub(ctrl_q.use_sub),
    .main_on(main_on), .sub_on(sub_on), .sel_clk(sel_clk)
  );

  sysclk_div #(.SYNC_N(SYNC_N)) u_div (
    .rst_n(rst_n), .sel_clk(sel_clk), .rate_in(ctrl_q.rate), .div_cnt(div_cnt),
    .act_rate(act_rate), .wrap(div_wrap), .cpu_clk(cpu_clk)
  );

  assign main_osc_en = !ctrl_q.halt_main;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk
  import sysclk_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h80
) (
  input logic              bus_clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [SEL_W:0]    wdata_lo,
  input logic [DATA_W-1:0] rd_data,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              main_osc_en,
  input logic              sub_active,
  input logic              main_on,
  input logic              sub_on,
  input logic              sel_clk,
  input logic [CNT_W-1:0]  div_cnt,
  input logic [SEL_W-1:0]  act_rate,
  input logic              div_wrap
);
  p_write_fields_r1: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=> ctrl_q[SEL_W:0] == $past(wdata_lo));

  p_other_addr_r1: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr != CTRL_ADDR) |=> $stable(ctrl_q));

  p_read_zero_r1: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (addr != CTRL_ADDR) |-> rd_data == '0);

  p_reserved_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    rd_data[DATA_W-1:CTRL_W] == '0);

  p_one_source_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0({main_on, sub_on}));

  p_stop_gate_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !main_osc_en |-> sub_active);

  p_restart_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR && !wdata_lo[SEL_W]) |=> main_osc_en);

  p_wrap_only_r8: assert property (@(negedge sel_clk) disable iff (!rst_n)
    (act_rate != $past(act_rate)) |-> (div_cnt == '0 && $past(div_wrap)));
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .bus_clk(bus_clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata_lo(wdata[sysclk_pkg::SEL_W:0]), .rd_data(rd_data), .ctrl_q(ctrl_q),
  .main_osc_en(main_osc_en), .sub_active(sub_active), .main_on(main_on), .sub_on(sub_on),
  .sel_clk(sel_clk), .div_cnt(div_cnt), .act_rate(act_rate), .div_wrap(div_wrap)
);

// File: tb/sim_sysclk_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_ctrl;
  logic       bus_clk = 1'b0;
  logic       main_clk = 1'b0;
  logic       sub_clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic       main_osc_en;
  logic       sub_active;
  logic       cpu_clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int edge_cnt = 0;
  realtime t_rise = 0.0;
  realtime min_hi = 1.0e9;
  bit mon = 1'b0;

  sysclk_ctrl u0 (
    .bus_clk(bus_clk), .rst_n(rst_n), .main_clk(main_clk), .sub_clk(sub_clk),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .main_osc_en(main_osc_en), .sub_active(sub_active), .cpu_clk(cpu_clk)
  );

  always #10 bus_clk = ~bus_clk;
  always #7 if (main_osc_en !== 1'b0) main_clk = ~main_clk;
  always #150 sub_clk = ~sub_clk;

  always @(posedge cpu_clk) begin
    edge_cnt = edge_cnt + 1;
    t_rise = $realtime;
  end
  always @(negedge cpu_clk) begin
    if (mon && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_ref(input bit sub, input int n);
    for (int i = 0; i < n; i++) begin
      if (sub) @(posedge sub_clk);
      else @(posedge main_clk);
    end
  endtask

  task automatic measure(input bit sub, input int n, output int e, output int h);
    int e0;
    wait_ref(sub, 1);
    #3;
    e0 = edge_cnt;
    h = 0;
    for (int i = 0; i < n; i++) begin
      wait_ref(sub, 1);
      #3;
      h += int'(cpu_clk);
    end
    e = edge_cnt - e0;
  endtask

  function automatic int exp_ratio(input int code);
    if (code < 4) return 1;
    return 1 << (code - 3);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int e;
    int h;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge bus_clk);
    rst_n = 1'b1;
    @(negedge bus_clk);

    // R2 reset state
    bus_rd(8'h80, rv);
    chk(rv == 8'h00, "R2 reset value", rv, 0);
    chk(main_osc_en == 1'b1, "R2 main enabled", main_osc_en, 1);
    chk(sub_active == 1'b0, "R2 status clear", sub_active, 0);

    // R1 other address ignored
    bus_wr(8'h81, 8'h07);
    bus_rd(8'h81, rv);
    chk(rv == 8'h00, "R1 other read zero", rv, 0);
    bus_rd(8'h80, rv);
    chk(rv == 8'h00, "R1 other write ignored", rv, 0);

    // R1/R2 reserved bits
    bus_wr(8'h80, 8'hE7);
    bus_rd(8'h80, rv);
    chk(rv == 8'h07, "R2 reserved zero", rv, 7);

    // R6 stop ignored while main drives
    bus_wr(8'h80, 8'h14);
    bus_rd(8'h80, rv);
    chk(rv == 8'h04, "R6 stop ignored on main", rv, 4);
    chk(main_osc_en == 1'b1, "R6 main still enabled", main_osc_en, 1);

    // R3/R4 sweep of rate codes on the main clock
    for (int c = 0; c < 8; c++) begin
      bus_wr(8'h80, 8'(c));
      wait_ref(1'b0, 48);
      measure(1'b0, 256, e, h);
      chk(e == 256 / exp_ratio(c), $sformatf("R3 main code %0d edges", c), e, 256 / exp_ratio(c));
      if (c >= 4)
        chk(h == 128, $sformatf("R4 main code %0d duty", c), h, 128);
    end

    // R8 change from /8 to /4: no high phase shorter than two main periods
    bus_wr(8'h80, 8'h06);
    wait_ref(1'b0, 48);
    min_hi = 1.0e9;
    mon = 1'b1;
    bus_wr(8'h80, 8'h05);
    wait_ref(1'b0, 64);
    mon = 1'b0;
    chk(min_hi > 27.5, "R8 no shortened pulse", int'(min_hi), 28);

    // R6 stop together with a fresh switch request is dropped
    bus_wr(8'h80, 8'h18);
    bus_rd(8'h80, rv);
    chk(rv == 8'h08, "R6 stop dropped before switch", rv, 8);
    chk(main_osc_en == 1'b1, "R6 main kept before switch", main_osc_en, 1);
    repeat (150) @(negedge bus_clk);
    chk(sub_active == 1'b1, "R5 switched to slow", sub_active, 1);

    // R6 stop accepted once the slow clock drives
    bus_wr(8'h80, 8'h18);
    bus_rd(8'h80, rv);
    chk(rv == 8'h18, "R6 stop accepted", rv, 24);
    chk(main_osc_en == 1'b0, "R6 main stopped", main_osc_en, 0);

    // R3/R4/R5 slow clock rates
    for (int k = 0; k < 3; k++) begin
      int c;
      c = (k == 0) ? 0 : ((k == 1) ? 4 : 7);
      bus_wr(8'h80, 8'(8'h18 | c));
      wait_ref(1'b1, 48);
      measure(1'b1, 64, e, h);
      chk(e == 64 / exp_ratio(c), $sformatf("R3 R5 slow code %0d edges", c), e, 64 / exp_ratio(c));
      if (c >= 4)
        chk(h == 32, $sformatf("R4 slow code %0d duty", c), h, 32);
    end
    chk(sub_active == 1'b1, "R5 slow still active", sub_active, 1);

    // R7 return to main
    bus_wr(8'h80, 8'h00);
    chk(main_osc_en == 1'b1, "R7 main restarted", main_osc_en, 1);
    bus_rd(8'h80, rv);
    chk(rv == 8'h00, "R7 stop cleared", rv, 0);
    repeat (150) @(negedge bus_clk);
    chk(sub_active == 1'b0, "R5 back on main", sub_active, 0);
    wait_ref(1'b0, 48);
    measure(1'b0, 256, e, h);
    chk(e == 256, "R5 R3 main bypass after return", e, 256);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule